// File: doc/BRIEF.md
# Dual-rate aligned reset release

This block takes one asynchronous active-low reset request and turns it into two active-low reset outputs. One output feeds registers on a slow clock. The other feeds registers on a second clock that runs at exactly twice the slow rate and is phase aligned with it, so every slow rising edge coincides with a fast rising edge. Assertion reaches both outputs at once, with no clock involved. Release passes through a single synchronizer whose final transition is placed so that both register groups leave reset on the same common rising edge.

The parameter `MODE` picks the release mechanism, encoded as 0 (`REL_SLOW_FALL`) or 1 (`REL_FAST_QUAL`). In mode 0 the synchronizer stages are clocked on the falling edge of the slow clock. In mode 1 the stages run on the rising edge of the fast clock. A phase mark, derived from a toggle in the slow domain, then lets the last stage move only on fast edges that coincide with a slow falling edge. In both modes the outputs rise on a slow falling instant, and the first rising edge after that is shared by both clocks.

The block has no data path and no handshake. Its pins are plain clock and reset signals.

Top module: `dr_rst_align`

## Requirements
- R1: When `rst_in_n` goes low, both `rst_slow_n` and `rst_fast_n` go low in the same time step, without waiting for any clock edge.
- R2: `rst_slow_n` and `rst_fast_n` always carry the same value. A counter on the slow clock reset by `rst_slow_n` and a counter on the fast clock reset by `rst_fast_n` take their first step at the same instant. That instant is the slow rising edge that follows the release.
- R3: With `MODE` = 0, both outputs rise at the `SYNC_STAGES`-th falling edge of `clk_slow` after `rst_in_n` rises.
- R4: In either mode the outputs rise only at an instant where `clk_slow` falls. They never rise at a fast rising edge that coincides with a slow rising edge.
- R5: With `MODE` = 1, both outputs rise at the first rising edge of `clk_fast` that meets three conditions. It coincides with a falling edge of `clk_slow`. It is at least the `SYNC_STAGES`-th fast rising edge after `rst_in_n` rises. At least one slow rising edge has occurred since `rst_in_n` rose.
- R6: A low pulse on `rst_in_n` shorter than one slow period pulls both outputs low. The full release sequence of R3 or R5 then restarts, counted from the end of the pulse. This holds both after a completed release and in the middle of one.
- R7: While `rst_in_n` stays low and both clocks run, both outputs stay low.
- R8: Once released, both outputs stay high for as long as `rst_in_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock, phase aligned to `clk_fast` at half its rate |
| clk_fast | input | 1 | Fast clock, twice the slow rate |
| rst_in_n | input | 1 | Asynchronous active-low reset request |
| rst_slow_n | output | 1 | Active-low reset for the slow-clock register group |
| rst_fast_n | output | 1 | Active-low reset for the fast-clock register group |

## Verification
A corrupted phase mark in mode 1, such as one stuck high or inverted, moves the release onto a slow rising instant. At the ports this shows on the very first release: the fast counter steps half a slow period before the slow counter, and the output rise time falls on the wrong slow phase. A synchronizer stage that is skipped, stuck or clocked on the wrong edge shifts the rise time by whole fast or slow cycles against the expected instant, or holds the outputs low. A lost asynchronous clear leaves the outputs high a fraction of a nanosecond after `rst_in_n` falls, or lets a short glitch pass without restarting the sequence.

// File: rtl/dr_rst_pkg.sv
`timescale 1ns/100ps
package dr_rst_pkg;

  // Release mechanism selection
  typedef enum logic {
    REL_SLOW_FALL = 1'b0,  // stages clocked on the slow falling edge
    REL_FAST_QUAL = 1'b1   // stages on fast rising edge, last stage phase-qualified
  } rel_mode_e;

  // Fewest flops allowed between the asynchronous input and the outputs
  localparam int MIN_SYNC_STAGES = 2;

  // Clamp a requested depth to the minimum
  function automatic int eff_stages(input int req);
    return (req < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : req;
  endfunction

endpackage

// File: rtl/dr_sync_chain.sv
`timescale 1ns/100ps
// Shift chain with asynchronous clear and synchronous fill of ones.
// FALL_EDGE picks the active clock edge.
module dr_sync_chain #(
  parameter int DEPTH     = 2,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_n
);

  logic [DEPTH-1:0] stg;
  logic [DEPTH-1:0] stg_nxt;

  generate
    if (DEPTH == 1) begin : g_one
      assign stg_nxt = 1'b1;
    end else begin : g_many
      assign stg_nxt = {stg[DEPTH-2:0], 1'b1};
    end
  endgenerate

  generate
    if (FALL_EDGE) begin : g_neg
      always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) stg <= '0;
        else         stg <= stg_nxt;
      end
    end else begin : g_pos
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg <= '0;
        else         stg <= stg_nxt;
      end
    end
  endgenerate

  assign rel_n = stg[DEPTH-1];

endmodule

// File: rtl/dr_phase_mark.sv
`timescale 1ns/100ps
// Marks the fast cycle that ends on a slow falling edge.
// A slow-domain toggle is compared with its copy taken by the fast clock.
// The two differ only during the fast cycle right after a slow rising edge.
module dr_phase_mark (
  input  logic clk_slow,
  input  logic clk_fast,
  input  logic arst_n,
  output logic mark
);

  logic slow_tgl;
  logic slow_tgl_seen;

  always_ff @(posedge clk_slow or negedge arst_n) begin
    if (!arst_n) slow_tgl <= 1'b0;
    else         slow_tgl <= ~slow_tgl;
  end

  always_ff @(posedge clk_fast or negedge arst_n) begin
    if (!arst_n) slow_tgl_seen <= 1'b0;
    else         slow_tgl_seen <= slow_tgl;
  end

  assign mark = slow_tgl ^ slow_tgl_seen;

endmodule

// File: rtl/dr_gated_stage.sv
`timescale 1ns/100ps
// Final synchronizer flop. It clears asynchronously and only loads when enabled.
module dr_gated_stage (
  input  logic clk,
  input  logic arst_n,
  input  logic d_n,
  input  logic en,
  output logic q_n
);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  q_n <= 1'b0;
    else if (en)  q_n <= d_n;
  end

endmodule

// File: rtl/dr_rst_align.sv
`timescale 1ns/100ps
// Dual-rate aligned reset release: one synchronizer feeds both clock groups.
module dr_rst_align
  import dr_rst_pkg::*;
#(
  parameter rel_mode_e MODE        = REL_FAST_QUAL,
  parameter int        SYNC_STAGES = 2
) (
  input  logic clk_slow,
  input  logic clk_fast,
  input  logic rst_in_n,
  output logic rst_slow_n,
  output logic rst_fast_n
);

  localparam int STAGES = eff_stages(SYNC_STAGES);

  logic rel_n;

  generate
    if (MODE == REL_SLOW_FALL) begin : g_slow_fall
      // Every stage moves on the slow falling edge. The next common rising
      // edge then sees the release in both domains.
      dr_sync_chain #(
        .DEPTH     (STAGES),
        .FALL_EDGE (1'b1)
      ) u_chain (
        .clk    (clk_slow),
        .arst_n (rst_in_n),
        .rel_n  (rel_n)
      );
    end else begin : g_fast_qual
      logic pre_n;
      logic mark;

      dr_sync_chain #(
        .DEPTH     (STAGES - 1),
        .FALL_EDGE (1'b0)
      ) u_chain (
        .clk    (clk_fast),
        .arst_n (rst_in_n),
        .rel_n  (pre_n)
      );

      dr_phase_mark u_mark (
        .clk_slow (clk_slow),
        .clk_fast (clk_fast),
        .arst_n   (rst_in_n),
        .mark     (mark)
      );

      dr_gated_stage u_gate (
        .clk    (clk_fast),
        .arst_n (rst_in_n),
        .d_n    (pre_n),
        .en     (mark),
        .q_n    (rel_n)
      );
    end
  endgenerate

  assign rst_slow_n = rel_n;
  assign rst_fast_n = rel_n;

endmodule

// File: rtl/dr_rst_align_chk.sv
`timescale 1ns/100ps
module dr_rst_align_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk_slow,
  input logic clk_fast,
  input logic rst_in_n,
  input logic rst_slow_n,
  input logic rst_fast_n
);

  localparam int CW = $clog2(SYNC_STAGES + 1) + 1;

  // Fast rising edges since the last release of rst_in_n, saturating
  logic [CW-1:0] fast_edges;

  always_ff @(posedge clk_fast or negedge rst_in_n) begin
    if (!rst_in_n)                          fast_edges <= '0;
    else if (fast_edges < CW'(SYNC_STAGES)) fast_edges <= fast_edges + CW'(1);
  end

  // R1
  always @(negedge clk_fast) begin
    if (!rst_in_n) begin
      rst_low_chk: assert (!rst_slow_n && !rst_fast_n);
    end
  end

  // R4
  rise_on_slow_low_chk: assert property (@(negedge clk_fast) disable iff (!rst_in_n)
    ($rose(rst_fast_n) || $rose(rst_slow_n)) |-> !clk_slow);

  // R8
  hold_release_chk: assert property (@(negedge clk_fast) disable iff (!rst_in_n)
    (rst_fast_n && rst_slow_n) |=> (rst_fast_n && rst_slow_n));

  // R5
  min_latency_chk: assert property (@(negedge clk_fast) disable iff (!rst_in_n)
    rst_fast_n |-> (fast_edges >= CW'(SYNC_STAGES)));

endmodule

bind dr_rst_align dr_rst_align_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_slow   (clk_slow),
  .clk_fast   (clk_fast),
  .rst_in_n   (rst_in_n),
  .rst_slow_n (rst_slow_n),
  .rst_fast_n (rst_fast_n)
);

// File: tb/dr_rst_align_bench.sv
`timescale 1ns/100ps
module dr_rst_align_bench;
  import dr_rst_pkg::*;

  localparam int      STG      = 3;
  localparam realtime HALF     = 2.0;   // 250 MHz fast clock
  localparam realtime SLOW_PER = 8.0;

  logic clk_fast = 1'b0;
  logic clk_slow = 1'b0;
  logic rst_in_n = 1'b0;
  logic s0_n, f0_n, s1_n, f1_n;

  dr_rst_align #(.MODE(REL_SLOW_FALL), .SYNC_STAGES(STG)) u_dr_rst_align (
    .clk_slow (clk_slow), .clk_fast (clk_fast), .rst_in_n (rst_in_n),
    .rst_slow_n (s0_n), .rst_fast_n (f0_n));

  dr_rst_align #(.MODE(REL_FAST_QUAL), .SYNC_STAGES(STG)) u_dr_rst_align_q (
    .clk_slow (clk_slow), .clk_fast (clk_fast), .rst_in_n (rst_in_n),
    .rst_slow_n (s1_n), .rst_fast_n (f1_n));

  int checks = 0;
  int errors = 0;

  // ---------------- expected release model ----------------
  realtime t_rel_in = -1.0;
  always @(posedge rst_in_n) t_rel_in = $realtime;

  realtime seen_rel = -2.0;
  int      fe = 0, sf = 0;
  bit      seen_rise = 1'b0;
  realtime exp0 = -1.0, exp1 = -1.0;

  // Clock generator. Slow toggles on each fast rising edge, so the clocks stay aligned.
  initial begin
    forever begin
      #(HALF);
      clk_fast = ~clk_fast;
      if (clk_fast) begin
        clk_slow = ~clk_slow;
        if (!rst_in_n || seen_rel != t_rel_in) begin
          fe = 0; sf = 0; seen_rise = 1'b0; exp0 = -1.0; exp1 = -1.0;
          seen_rel = t_rel_in;
        end
        if (rst_in_n) begin
          fe++;
          if (clk_slow) seen_rise = 1'b1;
          else begin
            sf++;
            if (sf == STG && exp0 < 0.0) exp0 = $realtime;                      // R3
            if (fe >= STG && seen_rise && exp1 < 0.0) exp1 = $realtime;         // R5
          end
        end
      end
    end
  end

  // ---------------- observed rise instants and domain counters ----------------
  realtime a_s0 = -1.0, a_f0 = -1.0, a_s1 = -1.0, a_f1 = -1.0;
  always @(posedge s0_n) a_s0 = $realtime;
  always @(posedge f0_n) a_f0 = $realtime;
  always @(posedge s1_n) a_s1 = $realtime;
  always @(posedge f1_n) a_f1 = $realtime;

  int cs0, cf0, cs1, cf1;
  realtime ts0 = -1.0, tf0 = -1.0, ts1 = -1.0, tf1 = -1.0;
  always @(posedge clk_slow or negedge s0_n)
    if (!s0_n) cs0 <= 0; else begin if (cs0 == 0) ts0 = $realtime; cs0 <= cs0 + 1; end
  always @(posedge clk_fast or negedge f0_n)
    if (!f0_n) cf0 <= 0; else begin if (cf0 == 0) tf0 = $realtime; cf0 <= cf0 + 1; end
  always @(posedge clk_slow or negedge s1_n)
    if (!s1_n) cs1 <= 0; else begin if (cs1 == 0) ts1 = $realtime; cs1 <= cs1 + 1; end
  always @(posedge clk_fast or negedge f1_n)
    if (!f1_n) cf1 <= 0; else begin if (cf1 == 0) tf1 = $realtime; cf1 <= cf1 + 1; end

  // ---------------- helpers ----------------
  function automatic bit near(input realtime a, input realtime b);
    return ((a - b) < 0.05) && ((b - a) < 0.05);
  endfunction

  function automatic realtime slow_phase(input realtime t);
    return t - SLOW_PER * $floor(t / SLOW_PER);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input realtime act, input realtime expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.1f expected %0.1f", req, what, act, expv);
    end
  endtask

  task automatic chk_all_low(input string req);
    chk(!s0_n && !f0_n, req, "mode0 outputs low", real'(s0_n | f0_n), 0.0);
    chk(!s1_n && !f1_n, req, "mode1 outputs low", real'(s1_n | f1_n), 0.0);
  endtask

  // Compare one release against the model, for both instances
  task automatic verify_release(input string tag);
    // mode 0 release instant (R3, or R6 after a glitch)
    chk(exp0 > 0.0 && near(a_s0, exp0), tag, "mode0 slow rise time", a_s0, exp0);
    chk(near(a_f0, exp0), tag, "mode0 fast rise time", a_f0, exp0);
    // mode 1 release instant (R5, or R6 after a glitch)
    chk(exp1 > 0.0 && near(a_s1, exp1), tag, "mode1 slow rise time", a_s1, exp1);
    chk(near(a_f1, exp1), tag, "mode1 fast rise time", a_f1, exp1);
    // R4: rise on slow falling instant (slow falls at 6 mod 8)
    chk(near(slow_phase(a_f0), 6.0), "R4", "mode0 rise phase", slow_phase(a_f0), 6.0);
    chk(near(slow_phase(a_f1), 6.0), "R4", "mode1 rise phase", slow_phase(a_f1), 6.0);
    // R2: counters in both domains start together on the next common edge
    chk(near(ts0, tf0), "R2", "mode0 counter start skew", tf0, ts0);
    chk(near(tf0, exp0 + 4.0), "R2", "mode0 counter start", tf0, exp0 + 4.0);
    chk(near(ts1, tf1), "R2", "mode1 counter start skew", tf1, ts1);
    chk(near(tf1, exp1 + 4.0), "R2", "mode1 counter start", tf1, exp1 + 4.0);
    chk(s0_n && f0_n && s1_n && f1_n, "R8", "outputs high after release",
        real'(s0_n & f0_n & s1_n & f1_n), 1.0);
  endtask

  task automatic drop_reset();
    @(negedge clk_fast);
    #(0.5);
    rst_in_n = 1'b0;
    #(0.1);
    chk_all_low("R1");
  endtask

  // Release at a random offset from a fast rising edge, never on an edge
  task automatic release_random();
    int k;
    k = int'($urandom_range(79, 1));
    if (k % 20 == 0) k++;
    @(posedge clk_fast);
    #(0.1 * k);
    rst_in_n = 1'b1;
  endtask

  task automatic glitch(input string tag);
    int k;
    k = int'($urandom_range(75, 45));   // 4.5 .. 7.5 ns, below one slow period
    if ((4 + k) % 20 == 0) k++;
    @(posedge clk_fast);
    #(0.3);
    rst_in_n = 1'b0;
    #(0.1);
    chk_all_low(tag);
    #(0.1 * k - 0.1);
    rst_in_n = 1'b1;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd5511));
    #(1.0);
    chk_all_low("R1");
    #(30.0);
    chk_all_low("R7");

    // random release offsets
    for (int i = 0; i < 24; i++) begin
      release_random();
      #(40.0);
      verify_release((i % 2 == 0) ? "R3" : "R5");
      #(30.0);
      verify_release("R8");
      drop_reset();
      #(10.0 + 0.1 * $urandom_range(100, 0));
      chk_all_low("R7");
    end

    // glitch after a completed release
    for (int i = 0; i < 6; i++) begin
      release_random();
      #(40.0);
      verify_release("R3");
      glitch("R6");
      #(40.0);
      verify_release("R6");
      drop_reset();
      #(12.0);
    end

    // glitch in the middle of a release sequence
    for (int i = 0; i < 6; i++) begin
      release_random();
      #(2.0 + 0.1 * $urandom_range(30, 0));
      glitch("R6");
      #(40.0);
      verify_release("R6");
      drop_reset();
      #(12.0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000.0 * 4.0);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule